// File: doc/BRIEF.md
# Majority-Vote Asynchronous Serial Receiver

This block turns frames on an asynchronous serial line into parallel words. While idle it waits for a high-to-low transition on the synchronized line. It measures a programmable half bit period from that transition to reach the middle of the start bit. From there it steps through the data bits and the stop bit one programmable bit period at a time. At every bit centre it takes three samples on back-to-back clock cycles and decides the bit by two-out-of-three majority, so a single short disturbance cannot flip a bit.

Frames carry either seven or eight data bits, least significant bit first, framed by one low start bit and one high stop bit. The received word is held in an output register. A status byte carries three sticky flags: data ready, frame error and noise. Software clears them by writing ones to a clear input. A rejected start bit drops the frame and returns the receiver to idle. A bad stop bit is flagged, but the word is still delivered.

Top module: `vote_uart_rx`

## Requirements
- R1: The serial input passes through a two-flop synchronizer. Reception starts only on a high-to-low transition seen while idle with `en_i` high. While `en_i` is low, a whole frame on the line leaves `data_o` and `status_o` unchanged.
- R2: Take the clock edge at which the line is first low as edge 0. The start-bit centre is at edge `half_period_i`, and each later bit centre is `bit_period_i` edges after the previous one. The three samples of a bit are the line values at centre-1, centre and centre+1. A one-cycle disturbance at centre+2 has no effect.
- R3: Each bit value is the majority of its three samples. Two inverted samples invert the bit.
- R4: If at least two start-bit samples are high, the frame error flag is set, `data_o` and the ready flag are left as they were, and the receiver returns to idle.
- R5: If at least two stop-bit samples are low, the frame error flag is set, but the word is still written to `data_o` and the ready flag is set.
- R6: The noise flag is set whenever the three samples of any bit (start, data or stop) are not all equal, even when the majority decides correctly.
- R7: With `short_word_i` = 0 the frame has eight data bits, and the first data bit received lands in `data_o[0]`.
- R8: With `short_word_i` = 1 the frame has seven data bits, right-aligned in `data_o[6:0]`, and `data_o[7]` reads 0.
- R9: Start detection is masked from the start of a frame until its stop bit is decided. High-to-low transitions inside the data bits do not restart reception.
- R10: `status_o` bit 1 is frame error, bit 2 is noise and bit 5 is data ready. All other bits read 0. Each flag stays set until a cycle in which the matching bit of `status_clr_i` is 1. A new event in the same cycle as a clear keeps the flag set.
- R11: After reset `data_o` is 0 and `status_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| en_i | input | 1 | Receiver enable |
| short_word_i | input | 1 | 1 selects seven data bits, 0 selects eight |
| bit_period_i | input | CNT_W (16) | Bit length in clock cycles |
| half_period_i | input | CNT_W (16) | Delay from start edge to start-bit centre, in cycles |
| status_clr_i | input | 8 | Write-one-to-clear mask for the status flags |
| data_o | output | DATA_W (8) | Last received word |
| status_o | output | 8 | Sticky flags: bit 1 frame error, bit 2 noise, bit 5 data ready |

## Verification
The hardest situation to reach is a disturbance that lands on exactly one or two of the three sample cycles of a chosen bit. It depends on the synchronizer latency and on where the sampling points sit relative to the start edge. The bench drives the line one value per clock, indexed from the edge at which the line first reads low. It inverts the line at computed offsets from a bit centre: one offset, two offsets, or the cycle just outside the window. This shows that a lone disturbance only raises the noise flag, that two disturbances flip the bit, and that a disturbance outside the window does nothing. A start pulse shorter than the half period is driven to reach start-bit rejection, and a held-low stop bit is driven to reach the bad-stop path.

// File: rtl/vote_uart_rx_pkg.sv
package vote_uart_rx_pkg;
   typedef enum logic [1:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP
   } rx_phase_t;

   localparam int unsigned STAT_W  = 8;
   localparam int unsigned FE_POS  = 1;
   localparam int unsigned NF_POS  = 2;
   localparam int unsigned RDY_POS = 5;

   function automatic logic vote3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction
endpackage

// File: rtl/vote_uart_rx_sync.sv
module vote_uart_rx_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("vote_uart_rx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/vote_uart_rx_sampler.sv
module vote_uart_rx_sampler
   import vote_uart_rx_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             active_i,
   input  logic             rx_i,
   input  logic [CNT_W-1:0] half_i,
   input  logic [CNT_W-1:0] period_i,
   output logic             dec_valid_o,
   output logic             dec_bit_o,
   output logic             dec_noisy_o
);
   if (CNT_W < 3) begin : g_bad_cnt
      $error("vote_uart_rx_sampler: CNT_W must be at least 3");
   end

   localparam int unsigned TW = CNT_W + 1;
   localparam logic [TW-1:0] ONE = TW'(1);
   localparam logic [TW-1:0] TWO = TW'(2);

   logic [TW-1:0] cnt, tgt;
   logic          smp_a, smp_b;
   logic          at_early, at_mid, at_late;

   always_comb begin
      at_early = (cnt == tgt - ONE);
      at_mid   = (cnt == tgt);
      at_late  = (cnt == tgt + ONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         tgt   <= '0;
         smp_a <= 1'b1;
         smp_b <= 1'b1;
      end else if (start_i) begin
         cnt <= ONE;
         tgt <= {1'b0, half_i};
      end else if (active_i) begin
         if (at_late) begin
            cnt <= TWO;
            tgt <= {1'b0, period_i};
         end else begin
            cnt <= cnt + ONE;
         end
         if (at_early) smp_a <= rx_i;
         if (at_mid)   smp_b <= rx_i;
      end
   end

   assign dec_valid_o = active_i & at_late & ~start_i;
   assign dec_bit_o   = vote3(smp_a, smp_b, rx_i);
   assign dec_noisy_o = (smp_a != smp_b) | (smp_b != rx_i);
endmodule

// File: rtl/vote_uart_rx_frame.sv
module vote_uart_rx_frame
   import vote_uart_rx_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              short_i,
   input  logic              rx_i,
   input  logic              dec_valid_i,
   input  logic              dec_bit_i,
   input  logic              dec_noisy_i,
   output logic              start_o,
   output logic              active_o,
   output logic              done_o,
   output logic              start_bad_o,
   output logic              stop_bad_o,
   output logic              noise_o,
   output logic [DATA_W-1:0] word_o
);
   if (DATA_W < 2) begin : g_bad_width
      $error("vote_uart_rx_frame: DATA_W must be at least 2");
   end

   localparam int unsigned IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

   rx_phase_t         phase;
   logic              rx_prev;
   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  last_idx;
   logic [DATA_W-1:0] shreg;
   logic              dv;

   assign last_idx    = short_i ? IDX_W'(DATA_W - 2) : IDX_W'(DATA_W - 1);
   assign dv          = dec_valid_i & en_i;
   assign start_o     = (phase == RX_IDLE) & en_i & rx_prev & ~rx_i;
   assign active_o    = (phase != RX_IDLE);
   assign done_o      = dv & (phase == RX_STOP);
   assign start_bad_o = dv & (phase == RX_START) & dec_bit_i;
   assign stop_bad_o  = done_o & ~dec_bit_i;
   assign noise_o     = dv & dec_noisy_i;
   assign word_o      = short_i ? {1'b0, shreg[DATA_W-1:1]} : shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= RX_IDLE;
         rx_prev <= 1'b1;
         idx     <= '0;
         shreg   <= '0;
      end else begin
         rx_prev <= rx_i;
         if (!en_i) begin
            phase <= RX_IDLE;
         end else begin
            case (phase)
               RX_IDLE:  if (start_o) phase <= RX_START;
               RX_START: if (dv) begin
                  idx   <= '0;
                  phase <= dec_bit_i ? RX_IDLE : RX_DATA;
               end
               RX_DATA:  if (dv) begin
                  shreg <= {dec_bit_i, shreg[DATA_W-1:1]};
                  idx   <= idx + IDX_W'(1);
                  if (idx == last_idx) phase <= RX_STOP;
               end
               RX_STOP:  if (dv) phase <= RX_IDLE;
               default:  phase <= RX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/vote_uart_rx.sv
module vote_uart_rx
   import vote_uart_rx_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_i,
   input  logic              en_i,
   input  logic              short_word_i,
   input  logic [CNT_W-1:0]  bit_period_i,
   input  logic [CNT_W-1:0]  half_period_i,
   input  logic [STAT_W-1:0] status_clr_i,
   output logic [DATA_W-1:0] data_o,
   output logic [STAT_W-1:0] status_o
);
   logic              rx_s;
   logic              frame_start, frame_active, frame_done;
   logic              start_bad, stop_bad, bit_noise;
   logic              dec_valid, dec_bit, dec_noisy;
   logic [DATA_W-1:0] frame_word;
   logic              fe_q, nf_q, rdy_q;

   vote_uart_rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rx_s)
   );

   vote_uart_rx_sampler #(.CNT_W(CNT_W)) u_sampler (
      .clk(clk), .rst_n(rst_n),
      .start_i(frame_start), .active_i(frame_active), .rx_i(rx_s),
      .half_i(half_period_i), .period_i(bit_period_i),
      .dec_valid_o(dec_valid), .dec_bit_o(dec_bit), .dec_noisy_o(dec_noisy)
   );

   vote_uart_rx_frame #(.DATA_W(DATA_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .short_i(short_word_i), .rx_i(rx_s),
      .dec_valid_i(dec_valid), .dec_bit_i(dec_bit), .dec_noisy_i(dec_noisy),
      .start_o(frame_start), .active_o(frame_active), .done_o(frame_done),
      .start_bad_o(start_bad), .stop_bad_o(stop_bad), .noise_o(bit_noise),
      .word_o(frame_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o <= '0;
         fe_q   <= 1'b0;
         nf_q   <= 1'b0;
         rdy_q  <= 1'b0;
      end else begin
         if (frame_done) data_o <= frame_word;
         fe_q  <= (fe_q  & ~status_clr_i[FE_POS])  | start_bad | stop_bad;
         nf_q  <= (nf_q  & ~status_clr_i[NF_POS])  | bit_noise;
         rdy_q <= (rdy_q & ~status_clr_i[RDY_POS]) | frame_done;
      end
   end

   always_comb begin
      status_o          = '0;
      status_o[FE_POS]  = fe_q;
      status_o[NF_POS]  = nf_q;
      status_o[RDY_POS] = rdy_q;
   end
endmodule

// File: rtl/vote_uart_rx_chk.sv
module vote_uart_rx_chk
   import vote_uart_rx_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en_i,
   input logic              short_word_i,
   input logic [STAT_W-1:0] status_clr_i,
   input logic [STAT_W-1:0] status_o,
   input logic [DATA_W-1:0] data_o,
   input logic              done_i,
   input logic              start_bad_i,
   input logic              active_i,
   input logic              dec_valid_i,
   input logic              dec_noisy_i
);
   // R10
   fe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(status_o[FE_POS]) && !$past(status_clr_i[FE_POS]) |-> status_o[FE_POS]);

   // R5
   rdy_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> status_o[RDY_POS]);

   // R8
   short_msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_i && short_word_i |=> data_o[DATA_W-1] == 1'b0);

   // R4
   start_reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_bad_i |=> !active_i);

   // R4
   start_reject_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_bad_i |=> $stable(data_o));

   // R6
   noise_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid_i && dec_noisy_i && en_i |=> status_o[NF_POS]);
endmodule

bind vote_uart_rx vote_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en_i(en_i), .short_word_i(short_word_i),
   .status_clr_i(status_clr_i), .status_o(status_o), .data_o(data_o),
   .done_i(frame_done), .start_bad_i(start_bad), .active_i(frame_active),
   .dec_valid_i(dec_valid), .dec_noisy_i(dec_noisy)
);

// File: tb/vote_uart_rx_bench.sv
module vote_uart_rx_bench;
   localparam int DW = 8;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx = 1'b1;
   logic          en = 1'b1;
   logic          short_w = 1'b0;
   logic [CW-1:0] per = 16'd16;
   logic [CW-1:0] hlf = 16'd8;
   logic [7:0]    clr = 8'h00;
   logic [DW-1:0] data;
   logic [7:0]    status;

   int checks = 0;
   int fails  = 0;
   bit done_flag = 0;

   always #5 clk = ~clk;

   vote_uart_rx u_vote_uart_rx (
      .clk(clk), .rst_n(rst_n), .rx_i(rx), .en_i(en), .short_word_i(short_w),
      .bit_period_i(per), .half_period_i(hlf), .status_clr_i(clr),
      .data_o(data), .status_o(status)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Line index cyc matches the clock edge counted from the first low edge.
   task automatic send_frame(input int nb, input logic [7:0] d, input logic stopv,
                             input int gbit, input int ga, input int gb);
      logic b [0:9];
      logic v;
      int   ctr;
      b[0] = 1'b0;
      for (int i = 0; i < 9; i++) b[i+1] = (i < nb) ? d[i] : 1'b1;
      b[nb+1] = stopv;
      for (int cyc = 0; cyc < (nb + 2) * int'(per); cyc++) begin
         v = b[cyc / int'(per)];
         ctr = int'(hlf) + gbit * int'(per);
         if (gbit >= 0 && (cyc == ctr + ga || cyc == ctr + gb)) v = ~v;
         @(negedge clk);
         rx = v;
      end
      @(negedge clk);
      rx = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic clear_all();
      @(negedge clk);
      clr = 8'hFF;
      @(negedge clk);
      clr = 8'h00;
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      int sweep_bad;
      logic [7:0] exp8;
      repeat (5) @(negedge clk);
      // R11 reset state
      chk("R11 data after reset", 16'(data), 16'h0);
      chk("R11 status after reset", 16'(status), 16'h0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R7 R9 R1: eight-bit sweep of every word
      sweep_bad = 0;
      for (int w = 0; w < 256; w++) begin
         send_frame(8, 8'(w), 1'b1, -1, 0, 0);
         if (data !== 8'(w) || status !== 8'h20) sweep_bad++;
         chk("R7 eight-bit word", 16'(data), 16'(w));
         clear_all();
      end
      chk("R9 sweep frames all clean", 16'(sweep_bad), 16'h0);

      // R8 seven-bit sweep
      short_w = 1'b1;
      for (int w = 0; w < 128; w++) begin
         send_frame(7, 8'(w) | 8'h80, 1'b1, -1, 0, 0);
         chk("R8 seven-bit word", 16'(data), 16'(w));
         chk("R8 seven-bit status", 16'(status), 16'h20);
         clear_all();
      end
      short_w = 1'b0;

      // R9 alternating pattern full of falling edges
      send_frame(8, 8'hAA, 1'b1, -1, 0, 0);
      chk("R9 no restart inside frame", 16'(data), 16'hAA);
      chk("R9 status", 16'(status), 16'h20);
      clear_all();

      // R6 R3 single disturbance on data bit 2 at each window offset
      for (int off = -1; off <= 1; off++) begin
         send_frame(8, 8'h0F, 1'b1, 3, off, off);
         chk("R3 single disturbance outvoted", 16'(data), 16'h0F);
         chk("R6 noise flagged", 16'(status), 16'h24);
         clear_all();
      end

      // R3 two disturbances invert the bit
      send_frame(8, 8'h0F, 1'b1, 3, -1, 1);
      chk("R3 two disturbances flip bit", 16'(data), 16'h0B);
      chk("R6 noise on flipped bit", 16'(status), 16'h24);
      clear_all();

      // R2 disturbance just outside the window
      send_frame(8, 8'h3C, 1'b1, 5, 2, 2);
      chk("R2 outside window data", 16'(data), 16'h3C);
      chk("R2 outside window no noise", 16'(status), 16'h20);
      clear_all();

      // R2 independent half period
      hlf = 16'd5;
      send_frame(8, 8'h96, 1'b1, 0, -1, -1);
      chk("R2 short half period data", 16'(data), 16'h96);
      chk("R2 start sample at half period", 16'(status), 16'h24);
      clear_all();
      send_frame(8, 8'h69, 1'b1, 0, 2, 2);
      chk("R2 short half period outside", 16'(status), 16'h20);
      clear_all();
      per = 16'd12;
      hlf = 16'd6;
      send_frame(8, 8'hC3, 1'b1, -1, 0, 0);
      chk("R2 other bit period", 16'(data), 16'hC3);
      clear_all();
      per = 16'd16;
      hlf = 16'd8;

      // R6 noise on stop bit
      send_frame(8, 8'h81, 1'b1, 9, 0, 0);
      chk("R6 stop noise", 16'(status), 16'h24);
      clear_all();

      // R4 false start: short low pulse
      exp8 = data;
      @(negedge clk); rx = 1'b0;
      repeat (3) @(negedge clk);
      rx = 1'b1;
      repeat (200) @(negedge clk);
      chk("R4 false start status", 16'(status), 16'h02);
      chk("R4 false start data kept", 16'(data), 16'(exp8));
      clear_all();
      send_frame(8, 8'h5E, 1'b1, -1, 0, 0);
      chk("R4 back to idle after reject", 16'(data), 16'h5E);
      clear_all();

      // R5 bad stop still delivers
      send_frame(8, 8'h5A, 1'b0, -1, 0, 0);
      chk("R5 bad stop data", 16'(data), 16'h5A);
      chk("R5 bad stop status", 16'(status), 16'h22);

      // R10 sticky flags and selective clear
      send_frame(8, 8'h11, 1'b1, -1, 0, 0);
      chk("R10 frame error sticky", 16'(status), 16'h22);
      @(negedge clk); clr = 8'h20;
      @(negedge clk); clr = 8'h00;
      chk("R10 ready cleared alone", 16'(status), 16'h02);
      clear_all();
      chk("R10 all cleared", 16'(status), 16'h00);

      // R1 disabled receiver ignores a frame
      en = 1'b0;
      send_frame(8, 8'h3C, 1'b1, 3, 0, 0);
      chk("R1 disabled data", 16'(data), 16'h11);
      chk("R1 disabled status", 16'(status), 16'h00);
      en = 1'b1;
      repeat (2) @(negedge clk);
      send_frame(8, 8'hE7, 1'b1, -1, 0, 0);
      chk("R1 re-enabled", 16'(data), 16'hE7);

      finish_run();
   end
endmodule